// File: doc/BRIEF.md
# Lockable Secret Key Register File

This block keeps a secret key of 32 bytes on a plain byte-wide register bus (address, write strobe, read strobe, write data, registered read data). Next to the key sits one control register whose two policy bits decide whether the key bytes can be read, written, both, or neither. A third control bit, the freeze bit, can only be set from the bus. Once set, it pins the policy until a control-domain reset.

The key bytes live in their own reset domain, `vault_rst`, which stands for the backed-up supply's power-on reset. The control register and the read-data register are cleared when any of three other resets is high: main supply power-on, standby supply power-on, or host bus reset. After any of these control resets the key stays intact and is fully accessible again. All resets are synchronous and active high.

The key occupies addresses `KEY_BASE` to `KEY_BASE+31`, one byte per address, in order. The control register sits at `CTL_ADDR`. Every other address reads as zero and ignores writes.

Top module: `keyvault_regfile`

## Requirements
- R1: Every key byte becomes 0x00 when `vault_rst` is high. The three control resets leave the key bytes unchanged.
- R2: The control word uses bit 2 as write-block, bit 1 as read-block and bit 0 as freeze. The policy bits [2:1] decode as follows: 00 means read and write, 01 means write only, 10 means read only, 11 means no access.
- R3: While the read-block bit (bit 1) is 1, a read of any key address returns 0x00.
- R4: While the write-block bit (bit 2) is 1, writes to key addresses leave every stored byte unchanged.
- R5: While the freeze bit (bit 0) is 1, writes to the control register do not change bits 2 and 1.
- R6: The bus can only set the freeze bit, never clear it. A control write with bit 0 at 1 sets freeze and updates bits 2 and 1 in the same write.
- R7: Each of `main_rst`, `stby_rst` and `host_rst` clears the whole control register to 0x00.
- R8: A read of `CTL_ADDR` returns the control bits in [2:0], with every upper bit at 0.
- R9: `rdata` carries the result of a read one clock after `rd_en`. It holds its value in cycles with no read strobe.
- R10: An address that is neither a key byte nor the control register reads as 0x00, and a write to it changes no key byte and no control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| vault_rst | input | 1 | Synchronous reset of the key bytes only |
| main_rst | input | 1 | Main supply power-on reset, control domain |
| stby_rst | input | 1 | Standby supply power-on reset, control domain |
| host_rst | input | 1 | Host bus reset, control domain |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that only one address is presented per cycle, that the strobes are always 0 or 1 and never unknown, and that a reset pulse lasts at least one full clock edge. The stimulus drives every input on the falling edge from tasks. Each access lasts exactly one cycle, and resets are held across a rising edge. Read and write are never issued together, so no property has to deal with a same-cycle read-after-write.

// File: rtl/kv_pkg.sv
package kv_pkg;
  typedef struct packed {
    logic wr_block;
    logic rd_block;
    logic frozen;
  } kv_ctl_t;

  localparam int CTL_BITS = 3;
endpackage

// File: rtl/kv_decode.sv
module kv_decode #(
  parameter int ADDR_W    = 8,
  parameter int KEY_BYTES = 32,
  parameter int KEY_BASE  = 32,
  parameter int CTL_ADDR  = 96,
  localparam int IDX_W    = $clog2(KEY_BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              key_hit,
  output logic              ctl_hit,
  output logic [IDX_W-1:0]  key_idx
);
  logic [ADDR_W-1:0] off;

  always_comb begin
    off     = addr - ADDR_W'(KEY_BASE);
    key_hit = (off < ADDR_W'(KEY_BYTES));
    key_idx = off[IDX_W-1:0];
    ctl_hit = (addr == ADDR_W'(CTL_ADDR));
  end
endmodule

// File: rtl/kv_policy.sv
module kv_policy
  import kv_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_ctl,
  input  logic [CTL_BITS-1:0] wbits,
  output kv_ctl_t             ctl
);
  kv_ctl_t ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_ctl && !ctl_q.frozen) begin
      ctl_q.wr_block <= wbits[2];
      ctl_q.rd_block <= wbits[1];
      ctl_q.frozen   <= wbits[0];
    end
  end

  assign ctl = ctl_q;

  // R6: freeze is sticky
  p_freeze_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ctl_q.frozen |=> ctl_q.frozen);
  // R5: policy bits held while frozen
  p_policy_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    ctl_q.frozen |=> $stable(ctl_q));
  // R7: reset clears control
  p_ctl_reset_r7: assert property (@(posedge clk)
    $past(rst) |-> (ctl_q == '0));
endmodule

// File: rtl/kv_store.sv
module kv_store #(
  parameter int KEY_BYTES = 32,
  parameter int DATA_W    = 8,
  localparam int IDX_W    = $clog2(KEY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              blocked,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rbyte
);
  logic [KEY_BYTES-1:0][DATA_W-1:0] mem;

  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (we && !blocked && (idx == IDX_W'(g)))
        mem[g] <= wdata;
    end
  end

  assign rbyte = mem[idx];

  // R4: a blocked write changes nothing
  p_blocked_write_r4: assert property (@(posedge clk) disable iff (rst)
    (we && blocked) |=> $stable(mem));
  // R1: vault reset clears every byte
  p_vault_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (mem == '0));
endmodule

// File: rtl/keyvault_regfile.sv
module keyvault_regfile
  import kv_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int KEY_BYTES = 32,
  parameter int KEY_BASE  = 32,
  parameter int CTL_ADDR  = 96
) (
  input  logic              clk,
  input  logic              vault_rst,
  input  logic              main_rst,
  input  logic              stby_rst,
  input  logic              host_rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(KEY_BYTES);

  logic              ctl_rst;
  logic              key_hit;
  logic              ctl_hit;
  logic [IDX_W-1:0]  key_idx;
  logic [DATA_W-1:0] key_byte;
  logic [DATA_W-1:0] ctl_word;
  kv_ctl_t           ctl;

  assign ctl_rst  = main_rst | stby_rst | host_rst;
  assign ctl_word = {{(DATA_W-CTL_BITS){1'b0}}, ctl};

  kv_decode #(
    .ADDR_W(ADDR_W), .KEY_BYTES(KEY_BYTES),
    .KEY_BASE(KEY_BASE), .CTL_ADDR(CTL_ADDR)
  ) u_decode (
    .addr(addr), .key_hit(key_hit), .ctl_hit(ctl_hit), .key_idx(key_idx)
  );

  kv_policy u_policy (
    .clk(clk), .rst(ctl_rst), .wr_ctl(wr_en && ctl_hit),
    .wbits(wdata[CTL_BITS-1:0]), .ctl(ctl)
  );

  kv_store #(.KEY_BYTES(KEY_BYTES), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(vault_rst), .we(wr_en && key_hit),
    .blocked(ctl.wr_block), .idx(key_idx), .wdata(wdata), .rbyte(key_byte)
  );

  always_ff @(posedge clk) begin
    if (ctl_rst)
      rdata <= '0;
    else if (rd_en) begin
      if (key_hit)
        rdata <= ctl.rd_block ? '0 : key_byte;
      else if (ctl_hit)
        rdata <= ctl_word;
      else
        rdata <= '0;
    end
  end

  // R3: masked key reads
  p_masked_read_r3: assert property (@(posedge clk) disable iff (ctl_rst)
    (rd_en && key_hit && ctl.rd_block) |=> (rdata == '0));
  // R10: unmapped reads are zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (ctl_rst)
    (rd_en && !key_hit && !ctl_hit) |=> (rdata == '0));
  // R8: control readback
  p_ctl_readback_r8: assert property (@(posedge clk) disable iff (ctl_rst)
    (rd_en && ctl_hit) |=> (rdata[DATA_W-1:CTL_BITS] == '0));
  // R9: output holds without a read
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (ctl_rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_keyvault_regfile.sv
module test_keyvault_regfile;
  localparam int KB = 32;
  localparam int KBASE = 32;
  localparam int CADDR = 96;

  logic clk = 0;
  logic vault_rst = 1, main_rst = 1, stby_rst = 1, host_rst = 1;
  logic [7:0] addr = 0, wdata = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] rdata;

  int total = 0, bad = 0;
  logic [7:0] model [KB];

  always #5 clk = ~clk;

  keyvault_regfile i_keyvault_regfile (
    .clk(clk), .vault_rst(vault_rst), .main_rst(main_rst),
    .stby_rst(stby_rst), .host_rst(host_rst), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: main_rst = 1;
      1: stby_rst = 1;
      2: host_rst = 1;
      default: vault_rst = 1;
    endcase
    @(negedge clk);
    main_rst = 0; stby_rst = 0; host_rst = 0; vault_rst = 0;
  endtask

  task automatic read_all(string req, logic masked);
    logic [7:0] d;
    for (int i = 0; i < KB; i++) begin
      rd(8'(KBASE + i), d);
      check(req, d, masked ? 8'h00 : model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int i = 0; i < KB; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    main_rst = 0; stby_rst = 0; host_rst = 0; vault_rst = 0;
    check("R7 reset rdata", rdata, 8'h00);
    rd(8'(CADDR), d); check("R7 ctl after reset", d, 8'h00);
    read_all("R1 key after vault reset", 1'b0);

    // sweep all four policies; R2 R3 R4 R8
    for (int m = 0; m < 4; m++) begin
      pulse(m % 3);
      rd(8'(CADDR), d); check("R7 ctl cleared", d, 8'h00);
      wr(8'(CADDR), 8'hF8 | 8'(m << 1));
      rd(8'(CADDR), d); check("R8 ctl readback", d, 8'(m << 1));
      for (int i = 0; i < KB; i++) begin
        logic [7:0] v;
        v = 8'((i * 37 + m * 91 + 5) & 255);
        wr(8'(KBASE + i), v);
        if ((m & 2) == 0) model[i] = v;
      end
      read_all("R3 R2 policy read", (m & 1) != 0);
      wr(8'(CADDR), 8'h00);
      read_all("R4 R2 contents after policy", 1'b0);
    end

    // R9 hold
    rd(8'(KBASE + 3), d);
    @(negedge clk); check("R9 hold", rdata, model[3]);
    @(negedge clk); check("R9 hold", rdata, model[3]);

    // R10 unmapped sweep
    for (int a = 0; a < 256; a++) begin
      if (!((a >= KBASE && a < KBASE + KB) || a == CADDR)) begin
        wr(8'(a), 8'hFF);
        rd(8'(a), d); check("R10 unmapped read", d, 8'h00);
      end
    end
    rd(8'(CADDR), d); check("R10 ctl untouched", d, 8'h00);
    read_all("R10 key untouched", 1'b0);

    // R5 R6 freeze with write block
    wr(8'(CADDR), 8'h05);
    rd(8'(CADDR), d); check("R6 set with policy", d, 8'h05);
    wr(8'(CADDR), 8'h00);
    rd(8'(CADDR), d); check("R6 cannot clear", d, 8'h05);
    wr(8'(CADDR), 8'h02);
    rd(8'(CADDR), d); check("R5 policy frozen", d, 8'h05);
    for (int i = 0; i < KB; i++) wr(8'(KBASE + i), 8'h5A);
    pulse(0);
    rd(8'(CADDR), d); check("R7 main reset clears freeze", d, 8'h00);
    read_all("R4 R1 key kept across ctl reset", 1'b0);

    // freeze in read-write mode, then try to block
    wr(8'(CADDR), 8'h01);
    wr(8'(CADDR), 8'h06);
    rd(8'(CADDR), d); check("R5 frozen rw", d, 8'h01);
    wr(8'(KBASE + 7), 8'hC3); model[7] = 8'hC3;
    rd(8'(KBASE + 7), d); check("R5 still writable", d, 8'hC3);
    pulse(1);
    rd(8'(CADDR), d); check("R7 standby reset", d, 8'h00);
    wr(8'(CADDR), 8'h03);
    pulse(2);
    rd(8'(CADDR), d); check("R7 host reset", d, 8'h00);

    // R1 vault reset clears key
    pulse(3);
    for (int i = 0; i < KB; i++) model[i] = 8'h00;
    read_all("R1 vault clear", 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule